// File: doc/BRIEF.md
# Interrupt Mask and Priority Register Bank

This block is a bank of interrupt mask registers and interrupt priority registers on a simple single-cycle register bus. A mask register is split into 1-bit fields. A priority register is split into fields `PRIO_FW` bits wide. Each field is tied, through a parameter table, to one interrupt source identifier.

Mask registers always have two addresses. A write to the set address turns bits on, and a write to the clear address turns bits off. A priority register can be paired in the same way, or it can have a single address where a write replaces the whole value. Address decoding looks only at the low 29 bits of the bus address, so each register also appears in every alias window that differs in the top three bits.

After each write the bank compares the old and new value of every field. For each field that changed, it sends one event to the mapped source: an enable event if the new field value is nonzero, a disable event if it is zero. Events go out on two per-source vectors, which the per-source pending logic downstream consumes.

A response-phase state register sets what the outputs show in the cycle after each bus cycle. It has four states:
- `PH_IDLE`: no access happened.
- `PH_READ`: a read hit a register.
- `PH_WRITE`: a write hit a register.
- `PH_MISS`: the access matched no register.

It moves every clock:
- to `PH_MISS` on an access that matches nothing;
- to `PH_WRITE` on a write that hits a register;
- to `PH_READ` on a read that hits a register;
- to `PH_IDLE` when `bus_sel` is low.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset every register reads 0, and `bus_err`, `bus_rdata`, `src_enable_evt` and `src_disable_evt` are all 0.
- R2: A write to the set address of a paired register stores old OR `bus_wdata`.
- R3: A write to the clear address of a paired register stores old AND NOT `bus_wdata`.
- R4: A write to the only address of an unpaired priority register replaces its whole value with `bus_wdata`.
- R5: Only `bus_addr[28:0]` is compared with a register address, so accesses whose top three address bits differ reach the same register.
- R6: Field widths and numbering:
  - Mask registers have `REG_W` fields of 1 bit.
  - Priority registers have `REG_W/PRIO_FW` fields of `PRIO_FW` bits.
  - Field index k covers bits `[(NF-1-k)*FW +: FW]`, so index 0 is the most significant field.
  - Field k maps to entry k of that register's table slice. Entry e of a table is at bits `[e*SID_W +: SID_W]`.
- R7: Event rules:
  - Each field whose value changed raises bit `src_enable_evt[id]` if its new value is nonzero, or bit `src_disable_evt[id]` if its new value is zero.
  - A field whose value did not change raises no event.
  - A field mapped to id 0 raises no event.
- R8: A read at either the set or the clear address puts the stored value on `bus_rdata` in the next cycle. `bus_rdata` is 0 in every cycle that does not follow a read hit.
- R9: An access that matches no register has these effects:
  - In the next cycle `bus_err` is 1 for exactly one cycle and `bus_rdata` reads 0.
  - No register changes.
  - No event is raised.
- R10: Event bits are high only in the single cycle after a write hit, and are 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an unmatched access |
| src_enable_evt | output | NUM_SRC | Per-source enable events |
| src_disable_evt | output | NUM_SRC | Per-source disable events |

## Verification
The hardest case to reach from the ports is a write that changes some fields of a register but leaves others unchanged, while its set bits overlap bits that are already set. Only then does it show that events come from the field comparison and not from the written data.

The bench gets there by building up a register value with several set writes whose data overlap. It then rewrites a priority field with a different nonzero value, which must produce a fresh enable event. It also writes through an alias window, and hits the clear address of an unpaired register. That clear-address write must stay a miss, and the stored value must be unchanged when it is read back afterwards.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_MISS  = 2'd3
    } acc_phase_e;

    localparam int ALIAS_BITS = 29;

    function automatic logic addr_match(input logic [31:0] a, input logic [31:0] b);
        return a[ALIAS_BITS-1:0] == b[ALIAS_BITS-1:0];
    endfunction
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int          NUM_MASK    = 2,
    parameter int          NUM_PRIO    = 2,
    parameter int          NREG        = NUM_MASK + NUM_PRIO,
    parameter logic [31:0] MASK_BASE   = 32'h0408_0000,
    parameter logic [31:0] PRIO_BASE   = 32'h0408_0100,
    parameter logic [NUM_PRIO-1:0] PRIO_PAIRED = '1
) (
    input  logic            sel,
    input  logic [31:0]     addr,
    output logic [NREG-1:0] hit,
    output logic [NREG-1:0] clr_hit,
    output logic            miss
);
    logic [NREG-1:0] m_set;
    logic [NREG-1:0] m_clr;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g < NUM_MASK) begin : g_mask
            localparam logic [31:0] SET_A = MASK_BASE + 32'(8 * g);
            assign m_set[g] = addr_match(addr, SET_A);
            assign m_clr[g] = addr_match(addr, SET_A + 32'd4);
        end else begin : g_prio
            localparam logic [31:0] SET_A = PRIO_BASE + 32'(8 * (g - NUM_MASK));
            localparam bit          PAIR  = PRIO_PAIRED[g - NUM_MASK];
            assign m_set[g] = addr_match(addr, SET_A);
            if (PAIR) begin : g_pair
                assign m_clr[g] = addr_match(addr, SET_A + 32'd4);
            end else begin : g_single
                assign m_clr[g] = 1'b0;
            end
        end
    end

    assign hit     = {NREG{sel}} & (m_set | m_clr);
    assign clr_hit = {NREG{sel}} & m_clr;
    assign miss    = sel & ~(|(m_set | m_clr));
endmodule

// File: rtl/irq_bank_reg.sv
module irq_bank_reg #(
    parameter int W      = 8,
    parameter int FW     = 1,
    parameter bit PAIRED = 1'b1,
    parameter int NF     = W / FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          use_clr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  value,
    output logic [NF-1:0] fld_chg,
    output logic [NF-1:0] fld_nz
);
    logic [W-1:0] val_q;
    logic [W-1:0] val_nxt;

    always_comb begin
        val_nxt = val_q;
        if (wr_en) begin
            if (PAIRED) begin
                val_nxt = use_clr ? (val_q & ~wdata) : (val_q | wdata);
            end else begin
                val_nxt = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_nxt;
    end

    for (genvar k = 0; k < NF; k++) begin : g_fld
        localparam int LSB = (NF - 1 - k) * FW;
        assign fld_chg[k] = val_nxt[LSB +: FW] != val_q[LSB +: FW];
        assign fld_nz[k]  = |val_nxt[LSB +: FW];
    end

    assign value = val_q;
endmodule

// File: rtl/irq_bank_evmap.sv
module irq_bank_evmap #(
    parameter int NF      = 8,
    parameter int NUM_SRC = 16,
    parameter int SID_W   = $clog2(NUM_SRC),
    parameter logic [NF*SID_W-1:0] MAP = '0
) (
    input  logic [NF-1:0]      fld_chg,
    input  logic [NF-1:0]      fld_nz,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] dis
);
    always_comb begin
        en  = '0;
        dis = '0;
        for (int k = 0; k < NF; k++) begin
            for (int s = 1; s < NUM_SRC; s++) begin
                if (int'(MAP[k*SID_W +: SID_W]) == s && fld_chg[k]) begin
                    if (fld_nz[k]) en[s]  = 1'b1;
                    else           dis[s] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_bank_pkg::*;
#(
    parameter int          NUM_MASK  = 2,
    parameter int          NUM_PRIO  = 2,
    parameter int          REG_W     = 8,
    parameter int          PRIO_FW   = 4,
    parameter int          NUM_SRC   = 16,
    parameter logic [31:0] MASK_BASE = 32'h0408_0000,
    parameter logic [31:0] PRIO_BASE = 32'h0408_0100,
    parameter logic [NUM_PRIO-1:0] PRIO_PAIRED = 2'b10,
    parameter logic [NUM_MASK*REG_W*$clog2(NUM_SRC)-1:0] MASK_MAP = 64'h0FED_CBA9_8765_4321,
    parameter logic [NUM_PRIO*(REG_W/PRIO_FW)*$clog2(NUM_SRC)-1:0] PRIO_MAP = 16'h05C3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [31:0]        bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic               bus_err,
    output logic [NUM_SRC-1:0] src_enable_evt,
    output logic [NUM_SRC-1:0] src_disable_evt
);
    localparam int SID_W   = $clog2(NUM_SRC);
    localparam int NREG    = NUM_MASK + NUM_PRIO;
    localparam int PRIO_NF = REG_W / PRIO_FW;

    logic [NREG-1:0]    hit;
    logic [NREG-1:0]    clr_hit;
    logic               miss;
    logic [NREG-1:0]    wr_hit;
    logic [NREG-1:0]    wr_clr;
    logic [REG_W-1:0]   reg_val [NREG];
    logic [NUM_SRC-1:0] en_v    [NREG];
    logic [NUM_SRC-1:0] dis_v   [NREG];
    logic [NREG*REG_W-1:0] val_flat;

    irq_bank_decode #(
        .NUM_MASK   (NUM_MASK),
        .NUM_PRIO   (NUM_PRIO),
        .NREG       (NREG),
        .MASK_BASE  (MASK_BASE),
        .PRIO_BASE  (PRIO_BASE),
        .PRIO_PAIRED(PRIO_PAIRED)
    ) u_decode (
        .sel    (bus_sel),
        .addr   (bus_addr),
        .hit    (hit),
        .clr_hit(clr_hit),
        .miss   (miss)
    );

    assign wr_hit = hit & {NREG{bus_wr}};
    assign wr_clr = clr_hit & {NREG{bus_wr}};

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign val_flat[g*REG_W +: REG_W] = reg_val[g];
        if (g < NUM_MASK) begin : g_mask
            logic [REG_W-1:0] chg;
            logic [REG_W-1:0] nz;
            irq_bank_reg #(.W(REG_W), .FW(1), .PAIRED(1'b1)) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_hit[g]),
                .use_clr(wr_clr[g]),
                .wdata  (bus_wdata),
                .value  (reg_val[g]),
                .fld_chg(chg),
                .fld_nz (nz)
            );
            irq_bank_evmap #(
                .NF(REG_W), .NUM_SRC(NUM_SRC), .SID_W(SID_W),
                .MAP(MASK_MAP[g*REG_W*SID_W +: REG_W*SID_W])
            ) u_map (
                .fld_chg(chg),
                .fld_nz (nz),
                .en     (en_v[g]),
                .dis    (dis_v[g])
            );
        end else begin : g_prio
            localparam int P = g - NUM_MASK;
            logic [PRIO_NF-1:0] chg;
            logic [PRIO_NF-1:0] nz;
            irq_bank_reg #(.W(REG_W), .FW(PRIO_FW), .PAIRED(PRIO_PAIRED[P])) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_hit[g]),
                .use_clr(wr_clr[g]),
                .wdata  (bus_wdata),
                .value  (reg_val[g]),
                .fld_chg(chg),
                .fld_nz (nz)
            );
            irq_bank_evmap #(
                .NF(PRIO_NF), .NUM_SRC(NUM_SRC), .SID_W(SID_W),
                .MAP(PRIO_MAP[P*PRIO_NF*SID_W +: PRIO_NF*SID_W])
            ) u_map (
                .fld_chg(chg),
                .fld_nz (nz),
                .en     (en_v[g]),
                .dis    (dis_v[g])
            );
        end
    end

    logic [REG_W-1:0]   rd_mux;
    logic [NUM_SRC-1:0] en_all;
    logic [NUM_SRC-1:0] dis_all;

    always_comb begin
        rd_mux  = '0;
        en_all  = '0;
        dis_all = '0;
        for (int g = 0; g < NREG; g++) begin
            if (hit[g]) rd_mux = rd_mux | reg_val[g];
            en_all  = en_all  | en_v[g];
            dis_all = dis_all | dis_v[g];
        end
    end

    acc_phase_e phase_q;
    acc_phase_e phase_nxt;

    always_comb begin
        if (miss)        phase_nxt = PH_MISS;
        else if (|hit)   phase_nxt = bus_wr ? PH_WRITE : PH_READ;
        else             phase_nxt = PH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_nxt;
    end

    logic [REG_W-1:0]   rd_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] dis_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            en_q  <= '0;
            dis_q <= '0;
        end else begin
            rd_q  <= rd_mux;
            en_q  <= en_all;
            dis_q <= dis_all;
        end
    end

    always_comb begin
        bus_rdata       = '0;
        bus_err         = 1'b0;
        src_enable_evt  = '0;
        src_disable_evt = '0;
        unique case (phase_q)
            PH_IDLE:  ;
            PH_READ:  bus_rdata = rd_q;
            PH_WRITE: begin
                src_enable_evt  = en_q;
                src_disable_evt = dis_q;
            end
            PH_MISS:  bus_err = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
    parameter int REG_W    = 8,
    parameter int NUM_SRC  = 16,
    parameter int NUM_MASK = 2,
    parameter int NREG     = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [REG_W-1:0]      bus_rdata,
    input logic                  bus_err,
    input logic [NUM_SRC-1:0]    src_enable_evt,
    input logic [NUM_SRC-1:0]    src_disable_evt,
    input logic [NREG-1:0]       wr_hit,
    input logic [NREG-1:0]       wr_clr,
    input logic [NREG*REG_W-1:0] val_flat
);
    p_evt_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_enable_evt | src_disable_evt) != '0) |-> $past(bus_sel && bus_wr));

    p_err_after_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));

    p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0 && src_enable_evt == '0 && src_disable_evt == '0));

    p_rdata_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != '0) |-> $past(bus_sel && !bus_wr));

    p_no_src0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !src_enable_evt[0] && !src_disable_evt[0]);

    for (genvar i = 0; i < NREG; i++) begin : g_r
        p_hold_unwritten_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit[i] |=> $stable(val_flat[i*REG_W +: REG_W]));
        if (i < NUM_MASK) begin : g_m
            p_set_keeps_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit[i] && !wr_clr[i]) |=>
                (($past(val_flat[i*REG_W +: REG_W]) & ~val_flat[i*REG_W +: REG_W]) == '0));
            p_clr_adds_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_clr[i] |=>
                ((val_flat[i*REG_W +: REG_W] & ~$past(val_flat[i*REG_W +: REG_W])) == '0));
        end
    end
endmodule

bind irq_mask_bank irq_bank_chk #(
    .REG_W(REG_W), .NUM_SRC(NUM_SRC), .NUM_MASK(NUM_MASK), .NREG(NREG)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_rdata      (bus_rdata),
    .bus_err        (bus_err),
    .src_enable_evt (src_enable_evt),
    .src_disable_evt(src_disable_evt),
    .wr_hit         (wr_hit),
    .wr_clr         (wr_clr),
    .val_flat       (val_flat)
);

// File: tb/test_irq_mask_bank.sv
module test_irq_mask_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_err;
    logic [15:0] src_enable_evt;
    logic [15:0] src_disable_evt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0]  m_val [4];
    logic [7:0]  g_rd;
    logic        g_err;
    logic [15:0] g_en;
    logic [15:0] g_dis;

    always #10 clk = ~clk;

    irq_mask_bank i_irq_mask_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .src_enable_evt(src_enable_evt),
        .src_disable_evt(src_disable_evt)
    );

    function automatic logic [31:0] set_a(int r);
        return (r < 2) ? 32'h0408_0000 + 32'(8*r) : 32'h0408_0100 + 32'(8*(r-2));
    endfunction
    function automatic logic [31:0] clr_a(int r);
        return set_a(r) + 32'd4;
    endfunction
    function automatic int fw_of(int r);
        return (r < 2) ? 1 : 4;
    endfunction
    function automatic int src_of(int r, int k);
        case (r)
            0: return k + 1;
            1: return (k < 7) ? 9 + k : 0;
            2: return (k == 0) ? 3 : 12;
            default: return (k == 0) ? 5 : 0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(logic wr, logic [31:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        g_rd = bus_rdata; g_err = bus_err; g_en = src_enable_evt; g_dis = src_disable_evt;
    endtask

    task automatic wr_reg(string tag, int r, bit clr, logic [31:0] a, logic [7:0] d);
        logic [7:0]  nv;
        logic [15:0] een = '0;
        logic [15:0] edis = '0;
        int fw = fw_of(r);
        int nf = 8 / fw;
        if (r == 2)   nv = d;
        else if (clr) nv = m_val[r] & ~d;
        else          nv = m_val[r] | d;
        for (int k = 0; k < nf; k++) begin
            int lsb = (nf - 1 - k) * fw;
            logic [7:0] msk = 8'((1 << fw) - 1) << lsb;
            if (((nv ^ m_val[r]) & msk) != 0 && src_of(r, k) != 0) begin
                if ((nv & msk) != 0) een[src_of(r, k)] = 1'b1;
                else                 edis[src_of(r, k)] = 1'b1;
            end
        end
        acc(1'b1, a, d);
        chk({tag, " R7 enable events"}, 32'(g_en), 32'(een));
        chk({tag, " R7 disable events"}, 32'(g_dis), 32'(edis));
        chk({tag, " R9 no err on hit"}, 32'(g_err), 0);
        m_val[r] = nv;
    endtask

    task automatic rd_reg(string tag, logic [31:0] a, logic [7:0] exp);
        acc(1'b0, a, 8'h00);
        chk({tag, " R8 rdata"}, 32'(g_rd), 32'(exp));
        chk({tag, " R10 no events on read"}, 32'(g_en | g_dis), 0);
    endtask

    task automatic t_reset;
        chk("R1 err at reset", 32'(bus_err), 0);
        chk("R1 events at reset", 32'(src_enable_evt | src_disable_evt), 0);
        for (int r = 0; r < 4; r++) rd_reg("R1 reg zero", set_a(r), 8'h00);
    endtask

    task automatic t_mask_set;
        wr_reg("R2 set 0x81", 0, 0, set_a(0), 8'h81);
        chk("R6 top bit maps first id", 32'(g_en), 32'h0102);
        wr_reg("R2 overlapping set 0x83", 0, 0, set_a(0), 8'h83);
        chk("R7 only changed field", 32'(g_en), 32'h0080);
        rd_reg("R2 value", set_a(0), 8'h83);
        @(negedge clk);
        chk("R10 events one cycle only", 32'(src_enable_evt | src_disable_evt), 0);
    endtask

    task automatic t_mask_clr;
        wr_reg("R3 clr 0x01", 0, 1, clr_a(0), 8'h01);
        chk("R3 disable src8", 32'(g_dis), 32'h0100);
        wr_reg("R3 clr already clear", 0, 1, clr_a(0), 8'h01);
        chk("R7 no change no event", 32'(g_en | g_dis), 0);
        rd_reg("R8 read at clr addr", clr_a(0), 8'h82);
        rd_reg("R8 read at set addr", set_a(0), 8'h82);
    endtask

    task automatic t_alias;
        wr_reg("R5 alias write unmapped field", 1, 0, 32'hA408_0008, 8'h01);
        chk("R7 id0 no event", 32'(g_en | g_dis), 0);
        wr_reg("R5 alias write top field", 1, 0, 32'hE408_000C ^ 32'h4, 8'h80);
        chk("R5 src9 enable", 32'(g_en), 32'h0200);
        rd_reg("R5 read other alias", 32'h2408_000C, 8'h81);
    endtask

    task automatic t_prio_direct;
        wr_reg("R4 direct 0x30", 2, 0, set_a(2), 8'h30);
        chk("R6 top nibble src3", 32'(g_en), 32'h0008);
        wr_reg("R4 direct 0x05", 2, 0, set_a(2), 8'h05);
        chk("R4 src3 disabled", 32'(g_dis), 32'h0008);
        chk("R4 src12 enabled", 32'(g_en), 32'h1000);
        wr_reg("R7 nonzero to nonzero", 2, 0, 32'h6408_0100, 8'h07);
        chk("R7 re-enable src12", 32'(g_en), 32'h1000);
        rd_reg("R4 value", set_a(2), 8'h07);
    endtask

    task automatic t_prio_paired;
        wr_reg("R2 prio set 0x21", 3, 0, set_a(3), 8'h21);
        chk("R2 prio src5 enable", 32'(g_en), 32'h0020);
        wr_reg("R3 prio clr 0x20", 3, 1, clr_a(3), 8'h20);
        chk("R3 prio src5 disable", 32'(g_dis), 32'h0020);
        rd_reg("R3 prio value", clr_a(3), 8'h01);
    endtask

    task automatic t_miss;
        acc(1'b1, clr_a(2), 8'hFF);
        chk("R9 err on unpaired clr write", 32'(g_err), 1);
        chk("R9 no events on miss", 32'(g_en | g_dis), 0);
        @(negedge clk);
        chk("R9 err one cycle", 32'(bus_err), 0);
        rd_reg("R9 prio unchanged", set_a(2), 8'h07);
        acc(1'b0, 32'h0408_0200, 8'h00);
        chk("R9 err on unmapped read", 32'(g_err), 1);
        chk("R9 rdata zero on miss", 32'(g_rd), 0);
        for (int r = 0; r < 4; r++) rd_reg("R9 regs intact", set_a(r), m_val[r]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) m_val[r] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_set();
        t_mask_clr();
        t_alias();
        t_prio_direct();
        t_prio_paired();
        t_miss();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule